// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is an 8-bit synchronous serial port. A frame is always eight bits, least significant bit first. TxD changes on the falling edge of the transfer clock and RxD is sampled on its rising edge. The transfer clock comes from one of two sources. It can be divided down from the system clock, with a half period of `divisor + 1` system cycles. Or it can be taken from an external clock input. When the clock is internal it leaves the block on one of two clock output pins, picked by a 2-bit select field.

Two options extend the plain port. Continuous receive mode starts the next reception as soon as software reads the receive buffer, so no dummy byte has to be written to the transmit buffer. Data inversion flips every bit both on the way into the transmit buffer and on the way out of the receive buffer.

The register interface has a 2-bit address and 8-bit data. Reads return data one cycle after `rd_en`.

| addr | write | read |
|---|---|---|
| 0 | config: bit0 external clock, bits 2:1 pin select, bit3 continuous receive, bit4 inversion | the same config |
| 1 | no effect | status: bit0 transmit buffer empty, bit1 receive complete, bit2 overrun, bit3 busy |
| 2 | transmit buffer | receive buffer |
| 3 | divisor | divisor |

Top module: `sio_sync_port`

## Requirements
- R1: After reset the status register reads 0x01, config and divisor read 0, and TxD and both clock pins are high.
- R2: With the internal clock, a pin select of 00 sends the transfer clock to pin A and 01 sends it to pin B. Codes 10 and 11 send it to neither pin. A pin that is not selected stays high, and the frame is still transferred.
- R3: With config bit0 set, both clock pins stay high and the frame is shifted by edges of the external clock input.
- R4: With the internal clock, every half period of the transfer clock lasts divisor+1 system clock cycles.
- R5: A frame carries 8 bits, LSB first. TxD changes on the falling clock edge and RxD is sampled on the rising edge. With TxD looped back to RxD, the receive buffer returns the byte that was written.
- R6: While no frame is in progress, TxD and both clock pins are high.
- R7: With continuous receive off, only a write to address 2 starts a frame. A read of address 2 starts nothing.
- R8: With continuous receive on, a read of address 2 arms a new reception that runs without any write. That frame sends all ones on TxD.
- R9: With config bit4 set, the byte is stored inverted on a write to address 2 and returned inverted on a read of address 2.
- R10: Status bit1 sets when a received frame completes and clears when address 2 is read.
- R11: Status bit2 sets when a frame completes while status bit1 is still set. A read of address 2 clears it.
- R12: Status bit0 sets when the buffer moves into the shift register. A byte written during a frame follows as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after rd_en |
| ext_clk_i | input | 1 | External transfer clock |
| rxd_i | input | 1 | Serial receive data |
| txd_o | output | 1 | Serial transmit data |
| sclk_a_o | output | 1 | Transfer clock output pin A |
| sclk_b_o | output | 1 | Transfer clock output pin B |

## Verification
Some internal faults show up within one transfer-clock period. A bit counter or divisor fault changes the spacing of the pin edges or the number of rising edges per frame. A clock routed to the wrong pin, or a pin left low when it should be high, shows on the pin monitors during that same frame.

Flag and buffer faults take longer. A fault in the arming or buffer-empty logic shows as a frame that never starts, a frame that starts on its own, or the wrong byte order in a back-to-back pair. These show by the end of the following frame, through the status register or the TxD capture. A missing or doubled inversion appears at the next data read.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_DIV  = 2'd3
  } reg_addr_e;

  // config register, LSB = external clock select
  typedef struct packed {
    logic       invert;
    logic       cont_rx;
    logic [1:0] pin_sel;
    logic       ext_clk;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int NUM_PINS = 2;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_clk_i,
  output logic             sclk,
  output logic             fall_tick,
  output logic             rise_tick
);
  localparam int SYNC_W = 3;

  logic [DIV_W-1:0]  cnt;
  logic [SYNC_W-1:0] ext_q;
  logic              half_end;
  logic              ext_fall;
  logic              ext_rise;

  // external clock synchroniser plus edge history
  always_ff @(posedge clk) begin
    if (rst) ext_q <= '1;
    else     ext_q <= {ext_q[SYNC_W-2:0], ext_clk_i};
  end

  assign ext_fall = ext_q[SYNC_W-1] & ~ext_q[SYNC_W-2];
  assign ext_rise = ~ext_q[SYNC_W-1] & ext_q[SYNC_W-2];
  assign half_end = (cnt == div);

  // internal divider: toggles every div+1 cycles while a frame runs
  always_ff @(posedge clk) begin
    if (rst || !run || ext_mode) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (half_end) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  assign fall_tick = run & (ext_mode ? ext_fall : (half_end &  sclk));
  assign rise_tick = run & (ext_mode ? ext_rise : (half_end & ~sclk));
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              capture,
  input  logic              rxd_s,
  input  logic              fall_tick,
  input  logic              rise_tick,
  output logic              busy,
  output logic              load,
  output logic              txd,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              cap_en;
  logic              last_rise;

  assign load      = ~busy & start_req;
  assign last_rise = busy & rise_tick & (bit_cnt == LAST);
  assign rx_word   = {rxd_s, rx_sh[DATA_W-1:1]};
  assign rx_valid  = last_rise & cap_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      txd     <= 1'b1;
      tx_sh   <= '1;
      rx_sh   <= '0;
      bit_cnt <= '0;
      cap_en  <= 1'b0;
    end else if (load) begin
      busy    <= 1'b1;
      tx_sh   <= tx_word;
      txd     <= tx_word[0];
      bit_cnt <= '0;
      cap_en  <= capture;
    end else if (busy) begin
      if (rise_tick) begin
        rx_sh   <= rx_word;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end
      end else if (fall_tick && bit_cnt != '0) begin
        tx_sh <= {1'b1, tx_sh[DATA_W-1:1]};
        txd   <= tx_sh[1];
      end
    end
  end
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             cfg,
  output logic [DIV_W-1:0]  div,
  input  logic              load,
  input  logic              busy,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_word,
  output logic              start_req,
  output logic              rx_armed,
  output logic              tx_full,
  output logic              rx_done,
  output logic              overrun,
  output logic [DATA_W-1:0] tx_word
);
  logic [DATA_W-1:0] txbuf;
  logic [DATA_W-1:0] rxbuf;
  logic [DATA_W-1:0] inv_mask;
  logic              tx_wr;
  logic              rx_rd;
  reg_addr_e         sel;

  assign sel       = reg_addr_e'(addr);
  assign inv_mask  = {DATA_W{cfg.invert}};
  assign tx_wr     = wr_en & (sel == REG_DATA);
  assign rx_rd     = rd_en & (sel == REG_DATA);
  assign start_req = tx_full | rx_armed;
  assign tx_word   = tx_full ? txbuf : '1;

  // configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
      div <= '0;
    end else if (wr_en) begin
      if (sel == REG_CTRL) cfg <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (sel == REG_DIV)  div <= wdata[DIV_W-1:0];
    end
  end

  // transmit buffer and reception arming
  always_ff @(posedge clk) begin
    if (rst) begin
      txbuf    <= '0;
      tx_full  <= 1'b0;
      rx_armed <= 1'b0;
    end else begin
      if (load) begin
        tx_full  <= 1'b0;
        rx_armed <= 1'b0;
      end
      if (rx_rd && cfg.cont_rx) rx_armed <= 1'b1;
      if (tx_wr) begin
        txbuf    <= wdata ^ inv_mask;
        tx_full  <= 1'b1;
        rx_armed <= 1'b1;
      end
    end
  end

  // receive buffer and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rxbuf   <= '0;
      rx_done <= 1'b0;
      overrun <= 1'b0;
    end else if (rx_valid) begin
      rxbuf   <= rx_word;
      rx_done <= 1'b1;
      if (rx_done && !rx_rd) overrun <= 1'b1;
    end else if (rx_rd) begin
      rx_done <= 1'b0;
      overrun <= 1'b0;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (sel)
        REG_CTRL: rdata <= DATA_W'(cfg);
        REG_STAT: rdata <= DATA_W'({busy, overrun, rx_done, ~tx_full});
        REG_DATA: rdata <= rxbuf ^ inv_mask;
        REG_DIV:  rdata <= DATA_W'(div);
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_sync_port.sv
module sio_sync_port
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_clk_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              sclk_a_o,
  output logic              sclk_b_o
);
  ctrl_t             cfg;
  logic [DIV_W-1:0]  div;
  logic              ext_mode;
  logic              busy;
  logic              load;
  logic              start_req;
  logic              rx_armed;
  logic              tx_full;
  logic              rx_done;
  logic              overrun;
  logic              rx_valid;
  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_word;
  logic              sclk;
  logic              fall_tick;
  logic              rise_tick;
  logic              txd;
  logic [1:0]        rxd_q;
  logic [NUM_PINS-1:0] pin_q;

  assign ext_mode = cfg.ext_clk;

  always_ff @(posedge clk) begin
    if (rst) rxd_q <= '1;
    else     rxd_q <= {rxd_q[0], rxd_i};
  end

  sio_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg(cfg), .div(div), .load(load),
    .busy(busy), .rx_valid(rx_valid), .rx_word(rx_word),
    .start_req(start_req), .rx_armed(rx_armed), .tx_full(tx_full),
    .rx_done(rx_done), .overrun(overrun), .tx_word(tx_word)
  );

  sio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .run(busy), .div(div),
    .ext_clk_i(ext_clk_i), .sclk(sclk), .fall_tick(fall_tick),
    .rise_tick(rise_tick)
  );

  sio_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst(rst), .start_req(start_req), .tx_word(tx_word),
    .capture(rx_armed), .rxd_s(rxd_q[1]), .fall_tick(fall_tick),
    .rise_tick(rise_tick), .busy(busy), .load(load), .txd(txd),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  // one registered driver per clock pin; pin index equals its select code
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pin_q[p] <= 1'b1;
      else     pin_q[p] <= (!ext_mode && cfg.pin_sel == 2'(p)) ? sclk : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) txd_o <= 1'b1;
    else     txd_o <= txd;
  end

  assign sclk_a_o = pin_q[0];
  assign sclk_b_o = pin_q[1];
endmodule

// File: rtl/sio_sync_port_chk.sv
module sio_sync_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic       txd_o,
  input logic       sclk_a_o,
  input logic       sclk_b_o,
  input logic       ext_mode,
  input logic       cont_rx,
  input logic       busy,
  input logic       load,
  input logic       tx_full,
  input logic       rx_done,
  input logic       overrun,
  input logic       rx_armed,
  input logic       rx_valid
);
  logic data_rd;
  logic data_wr;
  assign data_rd = rd_en & (addr == 2'd2);
  assign data_wr = wr_en & (addr == 2'd2);

  AST_PINS_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(!sclk_a_o && !sclk_b_o));                                          // R2
  AST_EXT_PINS_HIGH: assert property (@(posedge clk) disable iff (rst)
    ext_mode |=> (sclk_a_o && sclk_b_o));                                // R3
  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (txd_o && sclk_a_o && sclk_b_o));                          // R6
  AST_NO_REARM_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (!cont_rx && data_rd && !data_wr && !rx_armed) |=> !rx_armed);       // R7
  AST_CONT_REARM: assert property (@(posedge clk) disable iff (rst)
    (cont_rx && data_rd) |=> rx_armed);                                  // R8
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rx_valid) |=> !rx_done);                                // R10
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_done && !data_rd) |=> overrun);                      // R11
  AST_TX_EMPTY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && !data_wr) |=> !tx_full);                                    // R12
endmodule

bind sio_sync_port sio_sync_port_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .txd_o(txd_o), .sclk_a_o(sclk_a_o), .sclk_b_o(sclk_b_o),
  .ext_mode(ext_mode), .cont_rx(cfg.cont_rx), .busy(busy), .load(load),
  .tx_full(tx_full), .rx_done(rx_done), .overrun(overrun),
  .rx_armed(rx_armed), .rx_valid(rx_valid)
);

// File: tb/sio_sync_port_tb.sv
module sio_sync_port_tb;
  logic       clk = 1'b0;
  logic       rst, wr_en, rd_en, ext_clk;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       rxd, txd, pa, pb;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;  // 50 MHz
  assign rxd = txd;       // loopback

  sio_sync_port u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_clk_i(ext_clk), .rxd_i(rxd),
    .txd_o(txd), .sclk_a_o(pa), .sclk_b_o(pb)
  );

  // monitor: written only here; bench requests a clear through mon_req
  bit          mon_ext = 0, chk_gap = 0;
  int          exp_half = 1, mon_req = 0, mon_seen = 0;
  int          gap = 0, gap_err = 0, ncap = 0, a_low = 0, b_low = 0;
  bit          seen = 0;
  logic [15:0] cap = '0;
  logic        prev_m = 1'b1, txd_prev = 1'b1;

  always @(negedge clk) begin
    logic m;
    if (mon_seen != mon_req) begin
      cap = '0; ncap = 0; gap = 0; gap_err = 0; seen = 0;
      a_low = 0; b_low = 0; mon_seen = mon_req;
    end
    m = mon_ext ? ext_clk : (pa & pb);
    if (!rst) begin
      if (!pa) a_low++;
      if (!pb) b_low++;
      if (m && !prev_m) begin cap = {txd_prev, cap[15:1]}; ncap++; end
      if (m != prev_m) begin
        if (seen && chk_gap && gap != exp_half) gap_err++;
        gap = 1; seen = 1;
      end else gap++;
    end
    prev_m = m; txd_prev = txd;
  end

  function automatic logic [7:0] inv8(input logic [7:0] v);
    return ~v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1 rd_en = 1; addr = a;
    @(posedge clk); #1 rd_en = 0; d = rdata;
  endtask

  task automatic mon_clear();
    mon_req++;
    @(negedge clk); #1;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, s);
      if (!s[3]) begin repeat (3) @(posedge clk); return; end
    end
    chk("R5 frame timeout", 0, 1);
  endtask

  task automatic run_frame(input logic [7:0] d);
    mon_clear();
    wr(2'd2, d);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL R5 watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r, d, d2, dv;
    int sel;
    void'($urandom(32'd4242));
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; ext_clk = 1;
    repeat (5) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    rd(2'd1, s); chk("R1 status", s, 8'h01);
    rd(2'd0, s); chk("R1 config", s, 8'h00);
    rd(2'd3, s); chk("R1 divisor", s, 8'h00);
    chk("R1 lines high", {txd, pa, pb}, 3'b111);

    // R4 R5 R10 R2: random bytes, random divisors, pin A and B
    for (int i = 0; i < 6; i++) begin
      d  = 8'($urandom);
      dv = 8'(3 + $urandom % 8);
      sel = i % 2;
      wr(2'd3, dv);
      wr(2'd0, 8'(sel << 1));
      exp_half = int'(dv) + 1; chk_gap = 1;
      run_frame(d);
      chk("R5 txd bits", cap[15:8], d);
      chk("R4 half period", gap_err, 0);
      chk("R5 bit count", ncap, 8);
      rd(2'd1, s); chk("R10 done set", s, 8'h03);
      if (sel == 0) chk("R2 pin A only", {a_low > 0, b_low == 0}, 2'b11);
      else          chk("R2 pin B only", {b_low > 0, a_low == 0}, 2'b11);
      rd(2'd2, r); chk("R5 loopback", r, d);
      rd(2'd1, s); chk("R10 done clear", s, 8'h01);
      chk("R6 idle lines", {txd, pa, pb}, 3'b111);
    end

    // R2 select code 10: no pin clocks, data still moves
    chk_gap = 0;
    wr(2'd0, 8'h04);
    d = 8'hC3;
    run_frame(d);
    chk("R2 no pin", {a_low == 0, b_low == 0}, 2'b11);
    rd(2'd2, r); chk("R2 data moved", r, d);

    // R7 read in plain mode starts nothing
    wr(2'd0, 8'h00); wr(2'd3, 8'd4); exp_half = 5;
    mon_clear();
    rd(2'd2, r);
    repeat (60) @(posedge clk);
    rd(2'd1, s); chk("R7 no frame", s, 8'h01);
    chk("R7 no clock", a_low, 0);

    // R8 continuous receive
    wr(2'd0, 8'h08);
    run_frame(8'h5A);
    mon_clear(); chk_gap = 1;
    rd(2'd2, r); chk("R5 first byte", r, 8'h5A);
    wait_idle();
    chk("R8 idle ones sent", cap[15:8], 8'hFF);
    chk("R8 bit count", ncap, 8);
    chk("R4 cont half period", gap_err, 0);
    rd(2'd1, s); chk("R8 done set", s[1], 1'b1);
    wr(2'd0, 8'h00);
    wait_idle();
    rd(2'd2, r); chk("R8 received", r, 8'hFF);
    repeat (40) @(posedge clk);
    rd(2'd1, s); chk("R7 stop after cont off", s, 8'h01);

    // R9 inversion
    wr(2'd0, 8'h10);
    d = 8'($urandom);
    run_frame(d);
    chk("R9 line inverted", cap[15:8], inv8(d));
    rd(2'd2, r); chk("R9 read restored", r, d);
    wr(2'd0, 8'h00);

    // R11 overrun
    d = 8'($urandom); d2 = 8'($urandom);
    run_frame(d);
    run_frame(d2);
    rd(2'd1, s); chk("R11 overrun set", s, 8'h07);
    rd(2'd2, r); chk("R11 latest byte", r, d2);
    rd(2'd1, s); chk("R11 overrun clear", s, 8'h01);

    // R12 buffer empty during shift, back-to-back
    chk_gap = 0;
    d = 8'($urandom); d2 = 8'($urandom);
    mon_clear();
    wr(2'd2, d);
    rd(2'd1, s); chk("R12 empty while busy", s, 8'h09);
    wr(2'd2, d2);
    rd(2'd1, s); chk("R12 full after write", s[0], 1'b0);
    for (int i = 0; i < 3000 && ncap < 16; i++) @(posedge clk);
    wait_idle();
    chk("R12 byte order", cap, {d2, d});
    rd(2'd2, r); chk("R12 second byte", r, d2);
    rd(2'd1, s); chk("R12 final status", s, 8'h01);

    // R3 external clock
    wr(2'd0, 8'h01);
    mon_ext = 1;
    mon_clear();
    d = 8'($urandom);
    wr(2'd2, d);
    repeat (5) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      #1 ext_clk = 0; repeat (10) @(posedge clk);
      #1 ext_clk = 1; repeat (10) @(posedge clk);
    end
    repeat (10) @(posedge clk);
    rd(2'd1, s); chk("R3 frame done", s, 8'h03);
    chk("R3 txd bits", cap[15:8], d);
    chk("R3 pins high", {a_low == 0, b_low == 0}, 2'b11);
    rd(2'd2, r); chk("R3 loopback", r, d);
    mon_ext = 0;
    wr(2'd0, 8'h00);
    chk("R6 final idle", {txd, pa, pb}, 3'b111);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule